// File: doc/BRIEF.md
# Sixteen-bit PWM Timer with Byte-Wide Register Access

This block is a 16-bit up-counter with two pulse-width outputs, reached from an 8-bit register bus. Software sets the period by writing a 16-bit TOP value. The counter runs from zero up to TOP and then starts again from zero. Each output has its own 16-bit compare value. An output goes high when the counter passes TOP and goes low when the counter reaches that output's compare value. The counter only moves on cycles where the `tick` input is high, so any prescaler outside the block sets the time base. With a 1 µs tick and TOP at 19999, the period is 20 ms, and compare values near 1000 to 2000 give servo-style pulses of about 1 to 2 ms.

Every 16-bit register is reached as two byte addresses, and all of them share one 8-bit holding latch. A write of the high byte only loads the latch. The following low-byte write then commits the latch and the new low byte to the target register in a single cycle. A read of the low byte copies the high byte of the same register into the latch in that cycle, and a later high-byte read returns what was latched. This makes a running counter readable as one consistent 16-bit snapshot. Because the latch is shared, a second 16-bit access that falls between the two halves of another one corrupts it.

Compare values are double-buffered: software reads and writes a buffer, and each output takes up its buffer value when the counter wraps at TOP. This means a duty change never cuts a period short.

Top module: `pwm16_timer`

## Requirements
- R1: After reset, the counter, both compare buffers, the holding latch and the control register are zero, TOP is 0xFFFF, and both outputs are low.
- R2: A write to a high-byte address (odd addresses 1, 3, 5, 7) loads only the shared latch and leaves the target register unchanged.
- R3: A write to a low-byte address (0 counter, 2 TOP, 4 compare A, 6 compare B) stores {latch, written byte} into the target in one cycle. The latch is shared by all four registers, so whatever last loaded it supplies the high byte.
- R4: A read of a low-byte address returns the register's low byte and, in the same cycle, copies its high byte into the latch. A read of a high-byte address returns the latch.
- R5: The counter advances by one on each cycle with `tick` high and holds otherwise. A counter low-byte write in a tick cycle takes precedence, and that tick is dropped.
- R6: On a tick with the counter equal to TOP, the counter restarts at zero, so one period lasts TOP+1 ticks.
- R7: Compare writes and reads reach a buffer. Each output loads its buffer into its working compare value only on the tick where the counter wraps at TOP.
- R8: An output's level is set on the wrap tick and cleared on a tick where the counter equals its working compare value. The level is high for compare+1 ticks per period: a compare of 0 gives one tick, and a compare at or above TOP keeps the level high.
- R9: The control register at address 8 holds a 2-bit mode for output A in bits 7:6 and for output B in bits 5:4. Mode 10 drives the level, mode 11 drives its inverse, and modes 00 and 01 hold the pin low. Bits 3:0 read as zero, so a written 0xA2 reads back as 0xA0 and puts both outputs in mode 10.
- R10: Addresses 9 to 15 read as zero, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Count enable from an external prescaler |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (low-byte reads update the latch) |
| addr | input | 4 | Register byte address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, combinational from addr |
| pwm_a | output | 1 | Output A |
| pwm_b | output | 1 | Output B |

## Verification
The hardest situations to reach from the ports are the ones where two things compete in time. One is a counter whose high byte changes between the two halves of a read. The bench stops the tick, loads the counter with 0x00FF, reads the low byte, then gives exactly one tick and reads the high byte, which must still show the snapshot value 0x00. The other is a compare update that arrives in the middle of a period. The bench steps the tick by hand so that it can show the old compare value ending the current pulse and the new one taking effect only after the wrap. Interleaved high-byte writes to two different registers, and a low-byte write that follows a read, show that the latch is shared.

// File: rtl/pwm16_pkg.sv
`timescale 1ns/1ps
package pwm16_pkg;
    localparam int ADDR_W = 4;
    localparam int N_OUT  = 2;
    // counter, TOP, then one compare per output
    localparam int N_WIDE = 2 + N_OUT;
    localparam int IDX_W  = $clog2(N_WIDE);
    localparam int IDX_CNT  = 0;
    localparam int IDX_TOP  = 1;
    localparam int IDX_CMP0 = 2;
    localparam logic [ADDR_W-1:0] CTRL_ADDR = 4'd8;

    typedef enum logic [1:0] {
        OM_OFF     = 2'b00,
        OM_OFF_ALT = 2'b01,
        OM_NORM    = 2'b10,
        OM_INV     = 2'b11
    } out_mode_e;

    // output i owns control bits [7-2i : 6-2i]
    function automatic int mode_lsb(input int i);
        return 6 - 2 * i;
    endfunction
endpackage

// File: rtl/pwm16_regs.sv
`timescale 1ns/1ps
module pwm16_regs
    import pwm16_pkg::*;
#(
    parameter int BUS_W = 8,
    localparam int CNT_W = 2 * BUS_W
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr_en,
    input  logic                        rd_en,
    input  logic [ADDR_W-1:0]           addr,
    input  logic [BUS_W-1:0]            wdata,
    input  logic [CNT_W-1:0]            cnt_q,
    output logic [BUS_W-1:0]            rdata,
    output logic                        cnt_load,
    output logic [CNT_W-1:0]            cnt_load_val,
    output logic [CNT_W-1:0]            top_q,
    output logic [N_OUT-1:0][CNT_W-1:0] cmp_buf_q,
    output logic [N_OUT-1:0][1:0]       mode_q,
    output logic [BUS_W-1:0]            temp_q
);
    typedef struct packed {
        logic [BUS_W-1:0]            temp;
        logic [CNT_W-1:0]            top;
        logic [N_OUT-1:0][CNT_W-1:0] cmp;
        logic [N_OUT-1:0][1:0]       mode;
    } regs_t;

    localparam regs_t RST_VAL = '{temp: '0, top: '1, cmp: '0, mode: '0};

    regs_t s_d, s_q;

    logic                          in_wide;
    logic                          hi_sel;
    logic [IDX_W-1:0]              idx;
    logic [N_WIDE-1:0][CNT_W-1:0]  wide_view;

    assign in_wide = (addr < ADDR_W'(2 * N_WIDE));
    assign hi_sel  = addr[0];
    assign idx     = addr[IDX_W:1];

    always_comb begin
        wide_view[IDX_CNT] = cnt_q;
        wide_view[IDX_TOP] = s_q.top;
        for (int i = 0; i < N_OUT; i++) begin
            wide_view[IDX_CMP0 + i] = s_q.cmp[i];
        end
    end

    // next state: latch, committed registers, control
    always_comb begin
        s_d          = s_q;
        cnt_load     = 1'b0;
        cnt_load_val = {s_q.temp, wdata};
        if (wr_en) begin
            if (in_wide) begin
                if (hi_sel) begin
                    s_d.temp = wdata;
                end else if (idx == IDX_W'(IDX_CNT)) begin
                    cnt_load = 1'b1;
                end else if (idx == IDX_W'(IDX_TOP)) begin
                    s_d.top = {s_q.temp, wdata};
                end else begin
                    for (int i = 0; i < N_OUT; i++) begin
                        if (idx == IDX_W'(IDX_CMP0 + i)) begin
                            s_d.cmp[i] = {s_q.temp, wdata};
                        end
                    end
                end
            end else if (addr == CTRL_ADDR) begin
                for (int i = 0; i < N_OUT; i++) begin
                    s_d.mode[i] = wdata[mode_lsb(i) +: 2];
                end
            end
        end else if (rd_en && in_wide && !hi_sel) begin
            s_d.temp = wide_view[idx][CNT_W-1:BUS_W];
        end
    end

    always_comb begin
        rdata = '0;
        if (in_wide) begin
            rdata = hi_sel ? s_q.temp : wide_view[idx][BUS_W-1:0];
        end else if (addr == CTRL_ADDR) begin
            for (int i = 0; i < N_OUT; i++) begin
                rdata[mode_lsb(i) +: 2] = s_q.mode[i];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= RST_VAL;
        end else begin
            s_q <= s_d;
        end
    end

    assign top_q     = s_q.top;
    assign cmp_buf_q = s_q.cmp;
    assign mode_q    = s_q.mode;
    assign temp_q    = s_q.temp;
endmodule

// File: rtl/pwm16_counter.sv
`timescale 1ns/1ps
module pwm16_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic [CNT_W-1:0] top_q,
    output logic [CNT_W-1:0] cnt_q,
    output logic             wrap
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } cnt_state_t;

    cnt_state_t s_d, s_q;

    assign wrap = tick && !load && (s_q.cnt == top_q);

    always_comb begin
        s_d = s_q;
        if (load) begin
            s_d.cnt = load_val;
        end else if (wrap) begin
            s_d.cnt = '0;
        end else if (tick) begin
            s_d.cnt = s_q.cnt + CNT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign cnt_q = s_q.cnt;
endmodule

// File: rtl/pwm16_outunit.sv
`timescale 1ns/1ps
module pwm16_outunit
    import pwm16_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step,
    input  logic             wrap,
    input  logic [CNT_W-1:0] cnt_q,
    input  logic [CNT_W-1:0] cmp_buf,
    input  logic [1:0]       mode,
    output logic             pin
);
    typedef struct packed {
        logic [CNT_W-1:0] cmp_act;
        logic             lvl;
    } out_state_t;

    out_state_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (wrap) begin
            s_d.lvl     = 1'b1;
            s_d.cmp_act = cmp_buf;
        end else if (step && (cnt_q == s_q.cmp_act)) begin
            s_d.lvl = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    always_comb begin
        case (out_mode_e'(mode))
            OM_NORM: pin = s_q.lvl;
            OM_INV:  pin = ~s_q.lvl;
            default: pin = 1'b0;
        endcase
    end
endmodule

// File: rtl/pwm16_timer.sv
`timescale 1ns/1ps
module pwm16_timer
    import pwm16_pkg::*;
#(
    parameter int BUS_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [3:0]        addr,
    input  logic [BUS_W-1:0]  wdata,
    output logic [BUS_W-1:0]  rdata,
    output logic              pwm_a,
    output logic              pwm_b
);
    localparam int CNT_W = 2 * BUS_W;

    logic [CNT_W-1:0]            cnt_q;
    logic [CNT_W-1:0]            top_q;
    logic [CNT_W-1:0]            cnt_load_val;
    logic                        cnt_load;
    logic                        wrap;
    logic                        step;
    logic [N_OUT-1:0][CNT_W-1:0] cmp_buf_q;
    logic [N_OUT-1:0][1:0]       mode_q;
    logic [BUS_W-1:0]            temp_q;
    logic [N_OUT-1:0]            pins;

    pwm16_regs #(.BUS_W(BUS_W)) u_regs (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_en        (wr_en),
        .rd_en        (rd_en),
        .addr         (addr),
        .wdata        (wdata),
        .cnt_q        (cnt_q),
        .rdata        (rdata),
        .cnt_load     (cnt_load),
        .cnt_load_val (cnt_load_val),
        .top_q        (top_q),
        .cmp_buf_q    (cmp_buf_q),
        .mode_q       (mode_q),
        .temp_q       (temp_q)
    );

    pwm16_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .load     (cnt_load),
        .load_val (cnt_load_val),
        .top_q    (top_q),
        .cnt_q    (cnt_q),
        .wrap     (wrap)
    );

    // a counter write swallows the tick of its cycle
    assign step = tick && !cnt_load;

    for (genvar g = 0; g < N_OUT; g++) begin : g_out
        pwm16_outunit #(.CNT_W(CNT_W)) u_out (
            .clk     (clk),
            .rst_n   (rst_n),
            .step    (step),
            .wrap    (wrap),
            .cnt_q   (cnt_q),
            .cmp_buf (cmp_buf_q[g]),
            .mode    (mode_q[g]),
            .pin     (pins[g])
        );
    end

    assign pwm_a = pins[0];
    assign pwm_b = pins[1];
endmodule

// File: rtl/pwm16_timer_chk.sv
`timescale 1ns/1ps
module pwm16_timer_chk
    import pwm16_pkg::*;
#(
    parameter int BUS_W = 8,
    localparam int CNT_W = 2 * BUS_W
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  tick,
    input logic                  wr_en,
    input logic                  rd_en,
    input logic [3:0]            addr,
    input logic [BUS_W-1:0]      wdata,
    input logic [CNT_W-1:0]      cnt_q,
    input logic [CNT_W-1:0]      top_q,
    input logic [BUS_W-1:0]      temp_q,
    input logic [N_OUT-1:0][1:0] mode_q,
    input logic                  pwm_a,
    input logic                  pwm_b
);
    logic cnt_wr;
    logic ctrl_wr;
    logic live_tick;
    assign cnt_wr    = wr_en && (addr == 4'd0);
    assign ctrl_wr   = wr_en && (addr == CTRL_ADDR);
    assign live_tick = tick && !cnt_wr;

    a_r2_hi_loads_latch: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr[0] && !addr[3]) |=> (temp_q == $past(wdata)));

    a_r3_top_commit: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == 4'd2) |=> (top_q == {$past(temp_q), $past(wdata)}));

    a_r4_cnt_snapshot: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !wr_en && addr == 4'd0) |=> (temp_q == $past(cnt_q[CNT_W-1:BUS_W])));

    a_r5_count_up: assert property (@(posedge clk) disable iff (!rst_n)
        (live_tick && cnt_q != top_q) |=> (cnt_q == CNT_W'($past(cnt_q) + CNT_W'(1))));

    a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !cnt_wr) |=> $stable(cnt_q));

    a_r6_wrap_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (live_tick && cnt_q == top_q) |=> (cnt_q == '0));

    a_r8_set_at_top: assert property (@(posedge clk) disable iff (!rst_n)
        (live_tick && cnt_q == top_q && mode_q[0] == 2'b10 && !ctrl_wr) |=> pwm_a);

    a_r9_inv_at_top: assert property (@(posedge clk) disable iff (!rst_n)
        (live_tick && cnt_q == top_q && mode_q[1] == 2'b11 && !ctrl_wr) |=> !pwm_b);

    a_r9_off_a: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_q[0][1] |-> !pwm_a);

    a_r9_off_b: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_q[1][1] |-> !pwm_b);
endmodule

bind pwm16_timer pwm16_timer_chk #(.BUS_W(BUS_W)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick   (tick),
    .wr_en  (wr_en),
    .rd_en  (rd_en),
    .addr   (addr),
    .wdata  (wdata),
    .cnt_q  (cnt_q),
    .top_q  (top_q),
    .temp_q (temp_q),
    .mode_q (mode_q),
    .pwm_a  (pwm_a),
    .pwm_b  (pwm_b)
);

// File: tb/test_pwm16_timer.sv
`timescale 1ns/1ps
module test_pwm16_timer;
    localparam logic [3:0] A_CNT = 4'd0, A_TOP = 4'd2, A_CMPA = 4'd4, A_CMPB = 4'd6;
    localparam logic [3:0] A_CTRL = 4'd8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic       wr_en = 1'b0;
    logic       rd_en = 1'b0;
    logic [3:0] addr = '0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic       pwm_a, pwm_b;

    int checks = 0;
    int errors = 0;
    int tick_div = 0;
    int tdiv_cnt = 0;
    bit done = 0;

    always #2 clk = ~clk;

    pwm16_timer i_pwm16_timer (
        .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .rd_en(rd_en),
        .addr(addr), .wdata(wdata), .rdata(rdata), .pwm_a(pwm_a), .pwm_b(pwm_b)
    );

    always @(negedge clk) begin
        if (tick_div != 0) begin
            if (tdiv_cnt >= tick_div - 1) begin
                tick = 1'b1;
                tdiv_cnt = 0;
            end else begin
                tick = 1'b0;
                tdiv_cnt++;
            end
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [7:0] d);
        @(negedge clk);
        rd_en = 1'b1; addr = a;
        #1 d = rdata;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic wr16(input logic [3:0] base, input logic [15:0] v);
        wr(base | 4'd1, v[15:8]);
        wr(base, v[7:0]);
    endtask

    task automatic rd16(input logic [3:0] base, output logic [15:0] v);
        logic [7:0] lo, hi;
        rd(base, lo);
        rd(base | 4'd1, hi);
        v = {hi, lo};
    endtask

    task automatic stop_ticks();
        @(negedge clk);
        tick_div = 0;
        tick = 1'b0;
    endtask

    task automatic step(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            tick = 1'b1;
            @(negedge clk);
            tick = 1'b0;
        end
    endtask

    task automatic measure(input int n, output int ha, output int hb);
        ha = 0; hb = 0;
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            ha += int'(pwm_a);
            hb += int'(pwm_b);
        end
    endtask

    task automatic config_run(input logic [15:0] top, input logic [15:0] ca,
                              input logic [15:0] cb, input logic [7:0] ctrl, input int div);
        stop_ticks();
        wr16(A_TOP, top);
        wr16(A_CMPA, ca);
        wr16(A_CMPB, cb);
        wr16(A_CNT, 16'd0);
        wr(A_CTRL, ctrl);
        @(negedge clk);
        tdiv_cnt = 0;
        tick_div = div;
    endtask

    task automatic t_reset();
        logic [15:0] v;
        logic [7:0] b;
        chk("R1 pwm_a after reset", pwm_a, 0);
        chk("R1 pwm_b after reset", pwm_b, 0);
        rd(A_TOP | 4'd1, b);
        chk("R1 latch after reset", b, 8'h00);
        rd16(A_CNT, v);  chk("R1 counter", v, 16'h0000);
        rd16(A_TOP, v);  chk("R1 top", v, 16'hFFFF);
        rd16(A_CMPA, v); chk("R1 compare A", v, 16'h0000);
        rd16(A_CMPB, v); chk("R1 compare B", v, 16'h0000);
        rd(A_CTRL, b);   chk("R1 control", b, 8'h00);
    endtask

    task automatic t_latch();
        logic [15:0] v;
        logic [7:0] b;
        wr16(A_TOP, 16'h1234);
        rd16(A_TOP, v); chk("R3 top 16-bit round trip", v, 16'h1234);
        wr(A_TOP | 4'd1, 8'h56);
        rd16(A_TOP, v); chk("R2 high byte alone leaves top", v, 16'h1234);
        wr(A_CMPA | 4'd1, 8'h11);
        wr(A_CMPB | 4'd1, 8'h22);
        wr(A_CMPA, 8'h33);
        rd16(A_CMPA, v); chk("R3 interleaved writes share latch", v, 16'h2233);
        rd(A_TOP, b);
        chk("R4 low-byte read value", b, 8'h34);
        wr(A_CMPB, 8'h44);
        rd16(A_CMPB, v); chk("R3 latch loaded by read feeds write", v, 16'h1244);
        wr16(A_CNT, 16'h00FF);
        rd(A_CNT, b); chk("R4 counter low byte", b, 8'hFF);
        step(1);
        rd(A_CNT | 4'd1, b); chk("R4 high byte is snapshot", b, 8'h00);
        rd16(A_CNT, v); chk("R5 counter advanced by one tick", v, 16'h0100);
        step(3);
        rd16(A_CNT, v); chk("R5 three ticks", v, 16'h0103);
        repeat (6) @(negedge clk);
        rd16(A_CNT, v); chk("R5 holds without tick", v, 16'h0103);
        // counter write in the same cycle as a tick
        wr(A_CNT | 4'd1, 8'h00);
        @(negedge clk);
        tick = 1'b1; wr_en = 1'b1; addr = A_CNT; wdata = 8'h20;
        @(negedge clk);
        tick = 1'b0; wr_en = 1'b0;
        rd16(A_CNT, v); chk("R5 write beats tick", v, 16'h0020);
    endtask

    task automatic t_decode();
        logic [7:0] b;
        wr(4'hC, 8'hFF);
        rd(4'hC, b);   chk("R10 unmapped reads zero", b, 8'h00);
        rd(A_CTRL, b); chk("R10 unmapped write ignored", b, 8'h00);
        wr(A_CTRL, 8'hA2);
        rd(A_CTRL, b); chk("R9 control readback", b, 8'hA0);
    endtask

    task automatic t_wrap();
        logic [15:0] v;
        stop_ticks();
        wr16(A_TOP, 16'd3);
        wr16(A_CNT, 16'd2);
        step(1);
        rd16(A_CNT, v); chk("R6 reaches top", v, 16'd3);
        step(1);
        rd16(A_CNT, v); chk("R6 restarts at zero", v, 16'd0);
    endtask

    task automatic t_pwm();
        int ha, hb;
        config_run(16'd9, 16'd3, 16'd0, 8'hB0, 1);
        repeat (30) @(negedge clk);
        measure(20, ha, hb);
        chk("R8 A high cmp+1 ticks", ha, 8);
        chk("R9 B inverted one-tick pulse", hb, 18);
        config_run(16'd9, 16'd9, 16'd12, 8'hB0, 1);
        repeat (30) @(negedge clk);
        measure(20, ha, hb);
        chk("R8 compare equal to top stays high", ha, 20);
        chk("R8 compare above top inverted stays low", hb, 0);
        config_run(16'd4, 16'd1, 16'd2, 8'hA0, 3);
        repeat (45) @(negedge clk);
        measure(30, ha, hb);
        chk("R5 slow tick A width", ha, 12);
        chk("R5 slow tick B width", hb, 18);
        wr(A_CTRL, 8'h50);
        measure(30, ha, hb);
        chk("R9 mode 01 holds A low", ha, 0);
        chk("R9 mode 01 holds B low", hb, 0);
        config_run(16'd19999, 16'd999, 16'd1999, 8'hA2, 1);
        repeat (20500) @(negedge clk);
        measure(20000, ha, hb);
        chk("R8 20000-tick period A", ha, 1000);
        chk("R8 20000-tick period B", hb, 2000);
    endtask

    task automatic t_dbuf();
        logic [15:0] v;
        stop_ticks();
        wr(A_CTRL, 8'hA2);
        wr16(A_TOP, 16'd9);
        wr16(A_CMPA, 16'd3);
        wr16(A_CNT, 16'd9);
        step(1);
        chk("R8 set on wrap tick", pwm_a, 1);
        wr16(A_CMPA, 16'd7);
        rd16(A_CMPA, v); chk("R7 buffer readback", v, 16'd7);
        step(3);
        chk("R7 still high before old match", pwm_a, 1);
        step(1);
        chk("R7 old compare ends this period", pwm_a, 0);
        step(6);
        chk("R7 set again at wrap", pwm_a, 1);
        step(7);
        chk("R7 new compare not yet matched", pwm_a, 1);
        step(1);
        chk("R7 new compare applies after wrap", pwm_a, 0);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_latch();
        t_decode();
        t_wrap();
        t_pwm();
        t_dbuf();
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual %0d expected %0d", 0, 1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule